// File: doc/BRIEF.md
# Per-Channel Drift Time Scaler Bank

This block times many detector channels at once against a single later trigger request. Each channel has its own small counter. A hit arrives as a valid strobe with a binary channel number. The decoder turns that number into a start pulse for one channel, and that channel's counter then advances once per bunch-crossing clock. The request reaches the block a fixed number of crossings after the particle passed. The count a channel holds at that moment therefore tells how long before the request its hit came, and the drift time follows from the known request latency.

One global request freezes every counter at the same edge. It copies all counts and running flags into a held snapshot and clears the bank for the next measurement. A channel that receives no request within the maximum run window gives up, returns to zero and waits for a new hit. An early noise hit therefore cannot block the channel for ever.

Top module: `drift_scaler_bank`

## Requirements
- R1: The bank has NUM_CH (default 24) independent channels. Every channel counts at the same time as the others, and a hit on one channel leaves all other channels unchanged.
- R2: A hit is taken when `hit_valid` is 1 at a rising edge, and `hit_addr` selects channel number `hit_addr` (binary, ADDR_W = 5 bits). Address values of NUM_CH or above start no channel.
- R3: A hit taken at edge k on an idle channel makes it busy with count 0. The count rises by one at each later edge, so a request taken at edge k+n reports the count n-1.
- R4: A channel stays busy for exactly MAX_RUN (default 48) edges after its start. A request at edge k+48 still reports count 47. If no request comes, the edge k+48 clears the count to 0 and drops busy.
- R5: Output `busy[c]` is 1 exactly while channel c is running.
- R6: A request taken at an edge copies every channel's count and busy flag, as they were before that edge, into `snap_cnt` and `snap_busy`. `snap_valid` is 1 for the one cycle after that edge. The snapshot keeps its value until the next request.
- R7: A hit on a channel that is already busy is ignored, and the channel keeps its original start.
- R8: A channel that is idle when the request comes reports count 0 with its snapshot busy flag at 0.
- R9: At the edge that takes a request, every counter clears to 0 and every busy flag drops. A hit presented at that same edge is dropped.
- R10: While `rst_n` is 0, all busy flags, counts, snapshot fields and `snap_valid` are 0.
- R11: In `snap_cnt`, channel c occupies bits [c*CNT_W +: CNT_W], with CNT_W = 6 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bx | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_valid | input | 1 | Hit strobe |
| hit_addr | input | 5 | Binary channel number of the hit |
| req | input | 1 | Global stop and latch request |
| busy | output | 24 | Live running flag per channel |
| snap_valid | output | 1 | One-cycle pulse after a request |
| snap_busy | output | 24 | Latched running flags |
| snap_cnt | output | 144 | Latched counts, 6 bits per channel |

## Verification
Three events can land on the same edge. A request can meet a fresh hit on an idle channel, and a request can meet a channel that has reached its last running cycle. A hit can also meet a channel that is timing out on that edge. The bench provokes each case by driving the hit and the request in one cycle, and by sweeping the gap between hit and request across the whole window and one step past it, including the gap of exactly 48. It judges each snapshot and the live busy flags against an arithmetic model that uses only the edge numbers of hits and requests.

// File: rtl/dtsb_pkg.sv
package dtsb_pkg;
   localparam int DEF_NUM_CH  = 24;
   localparam int DEF_ADDR_W  = 5;
   localparam int DEF_CNT_W   = 6;
   localparam int DEF_MAX_RUN = 48;

   typedef enum logic {
      CH_IDLE = 1'b0,
      CH_RUN  = 1'b1
   } ch_state_e;
endpackage

// File: rtl/dtsb_hit_decoder.sv
module dtsb_hit_decoder #(
   parameter int NUM_CH = dtsb_pkg::DEF_NUM_CH,
   parameter int ADDR_W = dtsb_pkg::DEF_ADDR_W
) (
   input  logic              hit_valid,
   input  logic [ADDR_W-1:0] hit_addr,
   output logic [NUM_CH-1:0] start_vec
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(c);
      assign start_vec[c] = hit_valid && (hit_addr == MY_ADDR);
   end
endmodule

// File: rtl/dtsb_chan_scaler.sv
module dtsb_chan_scaler #(
   parameter int CNT_W   = dtsb_pkg::DEF_CNT_W,
   parameter int MAX_RUN = dtsb_pkg::DEF_MAX_RUN
) (
   input  logic             clk_bx,
   input  logic             rst_n,
   input  logic             start,
   input  logic             req,
   output logic [CNT_W-1:0] cnt,
   output logic             busy
);
   import dtsb_pkg::*;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_RUN - 1);

   ch_state_e state;

   always_ff @(posedge clk_bx or negedge rst_n) begin
      if (!rst_n) begin
         state <= CH_IDLE;
         cnt   <= '0;
      end else if (req) begin
         state <= CH_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            CH_IDLE: begin
               if (start) begin
                  state <= CH_RUN;
                  cnt   <= '0;
               end
            end
            CH_RUN: begin
               if (cnt == LAST) begin
                  state <= CH_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= CH_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign busy = (state == CH_RUN);
endmodule

// File: rtl/dtsb_snapshot.sv
module dtsb_snapshot #(
   parameter int NUM_CH = dtsb_pkg::DEF_NUM_CH,
   parameter int CNT_W  = dtsb_pkg::DEF_CNT_W
) (
   input  logic                    clk_bx,
   input  logic                    rst_n,
   input  logic                    req,
   input  logic [NUM_CH*CNT_W-1:0] cnt_flat,
   input  logic [NUM_CH-1:0]       busy,
   output logic                    snap_valid,
   output logic [NUM_CH-1:0]       snap_busy,
   output logic [NUM_CH*CNT_W-1:0] snap_cnt
);
   always_ff @(posedge clk_bx or negedge rst_n) begin
      if (!rst_n) begin
         snap_valid <= 1'b0;
         snap_busy  <= '0;
         snap_cnt   <= '0;
      end else begin
         snap_valid <= req;
         if (req) begin
            snap_busy <= busy;
            snap_cnt  <= cnt_flat;
         end
      end
   end
endmodule

// File: rtl/drift_scaler_bank.sv
module drift_scaler_bank #(
   parameter int NUM_CH  = dtsb_pkg::DEF_NUM_CH,
   parameter int ADDR_W  = dtsb_pkg::DEF_ADDR_W,
   parameter int CNT_W   = dtsb_pkg::DEF_CNT_W,
   parameter int MAX_RUN = dtsb_pkg::DEF_MAX_RUN
) (
   input  logic                    clk_bx,
   input  logic                    rst_n,
   input  logic                    hit_valid,
   input  logic [ADDR_W-1:0]       hit_addr,
   input  logic                    req,
   output logic [NUM_CH-1:0]       busy,
   output logic                    snap_valid,
   output logic [NUM_CH-1:0]       snap_busy,
   output logic [NUM_CH*CNT_W-1:0] snap_cnt
);
   localparam int FLAT_W = NUM_CH * CNT_W;

   if (NUM_CH < 1 || NUM_CH > (1 << ADDR_W)) begin : g_bad_ch
      $error("NUM_CH must lie in 1..2**ADDR_W");
   end
   if (MAX_RUN < 2 || (MAX_RUN - 1) >= (1 << CNT_W)) begin : g_bad_run
      $error("MAX_RUN-1 must fit in CNT_W bits and MAX_RUN must be at least 2");
   end

   logic [NUM_CH-1:0] start_vec;
   logic [FLAT_W-1:0] cnt_flat;

   dtsb_hit_decoder #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W)
   ) u_dec (
      .hit_valid (hit_valid),
      .hit_addr  (hit_addr),
      .start_vec (start_vec)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dtsb_chan_scaler #(
         .CNT_W   (CNT_W),
         .MAX_RUN (MAX_RUN)
      ) u_scaler (
         .clk_bx (clk_bx),
         .rst_n  (rst_n),
         .start  (start_vec[c]),
         .req    (req),
         .cnt    (cnt_flat[c*CNT_W +: CNT_W]),
         .busy   (busy[c])
      );
   end

   dtsb_snapshot #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W)
   ) u_snap (
      .clk_bx     (clk_bx),
      .rst_n      (rst_n),
      .req        (req),
      .cnt_flat   (cnt_flat),
      .busy       (busy),
      .snap_valid (snap_valid),
      .snap_busy  (snap_busy),
      .snap_cnt   (snap_cnt)
   );
endmodule

// File: rtl/dtsb_checker.sv
module dtsb_checker #(
   parameter int NUM_CH  = dtsb_pkg::DEF_NUM_CH,
   parameter int ADDR_W  = dtsb_pkg::DEF_ADDR_W,
   parameter int CNT_W   = dtsb_pkg::DEF_CNT_W,
   parameter int MAX_RUN = dtsb_pkg::DEF_MAX_RUN
) (
   input logic                    clk_bx,
   input logic                    rst_n,
   input logic                    hit_valid,
   input logic [ADDR_W-1:0]       hit_addr,
   input logic                    req,
   input logic [NUM_CH-1:0]       busy,
   input logic [NUM_CH-1:0]       start_vec,
   input logic [NUM_CH*CNT_W-1:0] cnt_flat,
   input logic                    snap_valid,
   input logic [NUM_CH-1:0]       snap_busy,
   input logic [NUM_CH*CNT_W-1:0] snap_cnt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_RUN - 1);

   AST_DECODE_ONEHOT: assert property (@(posedge clk_bx) disable iff (!rst_n)
      $onehot0(start_vec)); // R2

   AST_REQ_CLEARS: assert property (@(posedge clk_bx) disable iff (!rst_n)
      req |=> (busy == '0)); // R9

   AST_SNAP_PULSE: assert property (@(posedge clk_bx) disable iff (!rst_n)
      req |=> snap_valid); // R6

   AST_SNAP_QUIET: assert property (@(posedge clk_bx) disable iff (!rst_n)
      !req |=> !snap_valid); // R6

   AST_SNAP_FLAGS: assert property (@(posedge clk_bx) disable iff (!rst_n)
      req |=> (snap_busy == $past(busy))); // R6

   AST_SNAP_HOLD: assert property (@(posedge clk_bx) disable iff (!rst_n)
      !req |=> ($stable(snap_busy) && $stable(snap_cnt))); // R6

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      AST_NO_OVERFLOW: assert property (@(posedge clk_bx) disable iff (!rst_n)
         cnt_flat[c*CNT_W +: CNT_W] <= LAST); // R4

      AST_IDLE_ZERO: assert property (@(posedge clk_bx) disable iff (!rst_n)
         !busy[c] |-> (cnt_flat[c*CNT_W +: CNT_W] == '0)); // R8

      AST_STEP_UP: assert property (@(posedge clk_bx) disable iff (!rst_n)
         (busy[c] && !req && cnt_flat[c*CNT_W +: CNT_W] != LAST) |=>
         (busy[c] && cnt_flat[c*CNT_W +: CNT_W] ==
          CNT_W'($past(cnt_flat[c*CNT_W +: CNT_W]) + 1'b1))); // R3

      AST_TIMEOUT: assert property (@(posedge clk_bx) disable iff (!rst_n)
         (busy[c] && !req && cnt_flat[c*CNT_W +: CNT_W] == LAST) |=> !busy[c]); // R4

      AST_START: assert property (@(posedge clk_bx) disable iff (!rst_n)
         (!busy[c] && start_vec[c] && !req) |=>
         (busy[c] && cnt_flat[c*CNT_W +: CNT_W] == '0)); // R3
   end
endmodule

bind drift_scaler_bank dtsb_checker #(
   .NUM_CH  (NUM_CH),
   .ADDR_W  (ADDR_W),
   .CNT_W   (CNT_W),
   .MAX_RUN (MAX_RUN)
) u_dtsb_chk (
   .clk_bx     (clk_bx),
   .rst_n      (rst_n),
   .hit_valid  (hit_valid),
   .hit_addr   (hit_addr),
   .req        (req),
   .busy       (busy),
   .start_vec  (start_vec),
   .cnt_flat   (cnt_flat),
   .snap_valid (snap_valid),
   .snap_busy  (snap_busy),
   .snap_cnt   (snap_cnt)
);

// File: tb/test_drift_scaler_bank.sv
module test_drift_scaler_bank;
   localparam int NCH  = 24;
   localparam int AW   = 5;
   localparam int CW   = 6;
   localparam int MRUN = 48;
   localparam int FW   = NCH * CW;

   logic          clk_bx = 1'b0;
   logic          rst_n = 1'b0;
   logic          hit_valid = 1'b0;
   logic [AW-1:0] hit_addr = '0;
   logic          req = 1'b0;
   logic [NCH-1:0] busy;
   logic           snap_valid;
   logic [NCH-1:0] snap_busy;
   logic [FW-1:0]  snap_cnt;

   int n_chk = 0;
   int n_bad = 0;
   int edge_no = 0;
   int start_e [NCH];
   logic [NCH-1:0] exp_sbusy = '0;
   logic [FW-1:0]  exp_scnt = '0;
   bit done = 0;

   always #5 clk_bx = ~clk_bx;
   always @(posedge clk_bx) edge_no <= edge_no + 1;

   drift_scaler_bank #(
      .NUM_CH (NCH), .ADDR_W (AW), .CNT_W (CW), .MAX_RUN (MRUN)
   ) i_drift_scaler_bank (
      .clk_bx (clk_bx), .rst_n (rst_n), .hit_valid (hit_valid),
      .hit_addr (hit_addr), .req (req), .busy (busy),
      .snap_valid (snap_valid), .snap_busy (snap_busy), .snap_cnt (snap_cnt)
   );

   task automatic chk(string tag, logic [FW-1:0] act, logic [FW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // busy before edge e, per the arithmetic model
   function automatic bit run_before(int c, int e);
      return start_e[c] >= 0 && (e - start_e[c]) <= MRUN;
   endfunction

   // drive one cycle at a negedge, apply the model for the next edge, check after it
   task automatic step(bit hv, int ha, bit rq, string tag);
      int e;
      logic [NCH-1:0] exp_live;
      hit_valid = hv;
      hit_addr  = AW'(ha);
      req       = rq;
      e = edge_no + 1;
      @(negedge clk_bx);
      hit_valid = 1'b0;
      req       = 1'b0;
      if (rq) begin
         for (int c = 0; c < NCH; c++) begin
            exp_sbusy[c] = run_before(c, e);
            exp_scnt[c*CW +: CW] = run_before(c, e) ? CW'(e - start_e[c] - 1) : '0;
         end
         for (int c = 0; c < NCH; c++) start_e[c] = -1;
      end else if (hv && ha < NCH) begin
         if (!run_before(ha, e)) start_e[ha] = e;
      end
      for (int c = 0; c < NCH; c++)
         exp_live[c] = start_e[c] >= 0 && (e - start_e[c]) < MRUN;
      chk({tag, " R5 live busy"}, FW'(busy), FW'(exp_live));
      chk({tag, " R6 snap_valid"}, FW'(snap_valid), FW'(rq));
      chk({tag, " R6 R8 snap_busy"}, FW'(snap_busy), FW'(exp_sbusy));
      chk({tag, " R3 R11 snap_cnt"}, snap_cnt, exp_scnt);
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, tag);
   endtask

   initial begin
      for (int c = 0; c < NCH; c++) start_e[c] = -1;
      repeat (3) @(negedge clk_bx);
      chk("R10 reset busy", FW'(busy), '0);
      chk("R10 reset snap_valid", FW'(snap_valid), '0);
      chk("R10 reset snap_busy", FW'(snap_busy), '0);
      chk("R10 reset snap_cnt", snap_cnt, '0);
      rst_n = 1'b1;
      @(negedge clk_bx);

      // R3 R4: sweep the hit-to-request gap across the window and past it
      for (int n = 1; n <= MRUN + 1; n++) begin
         step(1, n % NCH, 0, "R3 sweep hit");
         idle(n - 1, "R3 sweep wait");
         step(0, 0, 1, "R4 sweep req");
      end

      // R2: every address value, including those with no channel
      for (int a = 0; a < (1 << AW); a++) begin
         step(1, a, 0, "R2 addr hit");
         idle(3, "R2 addr wait");
         step(0, 0, 1, "R2 addr req");
      end

      // R1: all channels started on consecutive edges, one request
      for (int c = 0; c < NCH; c++) step(1, c, 0, "R1 stagger");
      idle(5, "R1 wait");
      step(0, 0, 1, "R1 req");

      // R7: second hit on a running channel is ignored
      step(1, 7, 0, "R7 first");
      idle(4, "R7 wait");
      step(1, 7, 0, "R7 second");
      idle(4, "R7 wait2");
      step(0, 0, 1, "R7 req");

      // R4: timeout rearms, then a new hit measures from scratch
      step(1, 4, 0, "R4 first");
      idle(MRUN - 1, "R4 run");
      step(1, 4, 0, "R4 hit on last cycle");
      step(1, 4, 0, "R4 rearm hit");
      idle(5, "R4 wait");
      step(0, 0, 1, "R4 req");

      // R9: hit together with request is dropped; bank clean afterwards
      step(1, 9, 0, "R9 pre");
      step(1, 9, 1, "R9 same edge");
      step(1, 11, 1, "R9 idle same edge");
      step(0, 0, 1, "R9 clean req");
      idle(6, "R6 hold");

      // R1: two channels in parallel, different ages
      step(1, 0, 0, "R1 a");
      idle(10, "R1 gap");
      step(1, 23, 0, "R1 b");
      idle(20, "R1 gap2");
      step(0, 0, 1, "R1 pair req");
      idle(2, "R6 hold2");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule